// File: doc/BRIEF.md
# External Bus Write Controller with Wait States and Acknowledge

This block runs write cycles on an external memory-style port. It makes a port clock from the core clock using a programmable divide ratio. Each access is timed on the edges of that port clock. A requester presents an address, a data word and a one-cycle request pulse. The controller then raises chip select with the address on a rising port-clock edge. It raises the write strobe on the next falling edge and turns on the data driver on the rising edge after that. It drops the strobe on a falling edge, and it releases chip select and the data driver on a rising edge.

The strobe can be lengthened in three ways. A programmed count adds whole port cycles. An external acknowledge input, sampled on rising port-clock edges, can hold the strobe for as long as it stays low. In the combined mode the count runs first and the acknowledge is looked at only after it. When acknowledge is seen high, the access closes in a fixed two-cycle tail. A hold option keeps chip select, address and data driven for one more port cycle after the strobe ends.

Top module: `ebw_write_ctrl`

## Requirements
- R1: `bus_clk` is low after reset. It toggles every `cfg_ratio`+1 core clock cycles, so each half period lasts `cfg_ratio`+1 core cycles.
- R2: A `req` pulse is accepted only while `busy` is low. `busy` rises on the next core cycle and stays high until chip select drops. A `req` seen while `busy` is high starts no access.
- R3: `bus_cs` and `bus_addr` become valid on a rising `bus_clk` edge. `bus_wr` rises on the next falling edge. `bus_wr` falls on a falling edge while `bus_cs` is still high, and it is high only while `bus_cs` is high.
- R4: `bus_oe` rises on the first rising `bus_clk` edge after `bus_wr` rises. `bus_addr` and `bus_data` hold the accepted values for as long as `bus_cs` is high.
- R5: With `cfg_mode`=2'b00 (count only), the strobe lasts `cfg_wait`+1 port cycles and `bus_ack` has no effect. A count of 0 gives a one-cycle strobe.
- R6: With `cfg_mode`=2'b01 (acknowledge only), `cfg_wait` is ignored. `bus_ack` is sampled on every rising edge, starting with the first rising edge after `bus_wr` rises, and a low sample keeps the strobe high.
- R7: Let the rising edge where `bus_ack` is first taken high be the j-th after the strobe started. Then `bus_wr` falls on the falling edge after rising edge j+1, so the strobe lasts j+1 port cycles, and `bus_cs` drops on rising edge j+2.
- R8: With `cfg_mode`=2'b10 or 2'b11 (combined), `bus_ack` is sampled only from rising edge `cfg_wait`+1 onward. The strobe lasts max(`cfg_wait`+1, first high sample index)+1 port cycles.
- R9: With `cfg_hold`=0, `bus_cs` and `bus_oe` drop on the first rising edge after `bus_wr` falls. With `cfg_hold`=1 they drop one port cycle later.
- R10: The mode, wait count, hold bit, address and data are captured when the request is accepted. Changes to these inputs during an access have no effect on it.
- R11: While `rst` is high, `busy`, `bus_clk`, `bus_cs`, `bus_wr` and `bus_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ratio | input | RATIO_W | Port clock half period minus one, in core cycles |
| cfg_mode | input | 2 | Stretch mode: 00 count, 01 acknowledge, 1x combined |
| cfg_wait | input | WAIT_W | Wait-state count in port cycles |
| cfg_hold | input | 1 | Adds one port cycle of data and select hold |
| req | input | 1 | Write request pulse |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| busy | output | 1 | Access in progress |
| bus_clk | output | 1 | External port clock |
| bus_cs | output | 1 | Chip select, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_oe | output | 1 | Data driver enable |
| bus_addr | output | ADDR_W | Address bus |
| bus_data | output | DATA_W | Data bus value |
| bus_ack | input | 1 | Acknowledge; low stalls the strobe |

## Verification
The hardest case to reach is in combined mode, when the acknowledge goes high while wait states are still counting. The early high sample must be ignored, and the stall must then end on the exact edge given by R8. The bench reaches this case by counting rising port-clock edges during the strobe and raising the acknowledge after a chosen number of them. Some vector rows set that number below the wait count and others set it above. A second hard case is a request made in the middle of an access. The bench makes it while also changing the wait count and the address, then checks that neither the current access nor the idle time after it is affected.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  typedef enum logic [1:0] {
    MODE_COUNT = 2'd0,
    MODE_ACK   = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_BOTH2 = 2'd3
  } ebw_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_STROBE,
    ST_ACKSEEN,
    ST_RELEASE,
    ST_TAIL,
    ST_HOLD
  } ebw_state_e;
endpackage

// File: rtl/ebw_clkgen.sv
module ebw_clkgen #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pclk,
  output logic               rise_tick,
  output logic               fall_tick
);
  logic [RATIO_W-1:0] div_cnt;
  logic               wrap;

  assign wrap      = (div_cnt >= ratio);
  assign rise_tick = wrap && !pclk;
  assign fall_tick = wrap && pclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      pclk    <= 1'b0;
    end else if (wrap) begin
      div_cnt <= '0;
      pclk    <= ~pclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ebw_waitcnt.sv
module ebw_waitcnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              expired
);
  logic [WAIT_W-1:0] remain;

  assign expired = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (load)
      remain <= load_val;
    else if (dec && !expired)
      remain <= remain - 1'b1;
  end
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
  import ebw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fall,
  input  logic start,
  input  logic use_ack,
  input  logic ack,
  input  logic wait_done,
  input  logic hold,
  output logic busy,
  output logic cs,
  output logic wr,
  output logic oe,
  output logic wait_load,
  output logic wait_dec
);
  ebw_state_e st;

  assign wait_load = (st == ST_SETUP) && fall;
  assign wait_dec  = (st == ST_STROBE) && rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      cs   <= 1'b0;
      wr   <= 1'b0;
      oe   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_ARM;
          busy <= 1'b1;
        end
        ST_ARM: if (rise) begin
          st <= ST_SETUP;
          cs <= 1'b1;
        end
        ST_SETUP: if (fall) begin
          st <= ST_STROBE;
          wr <= 1'b1;
        end
        ST_STROBE: if (rise) begin
          oe <= 1'b1;
          if (!wait_done)          st <= ST_STROBE;
          else if (use_ack && !ack) st <= ST_STROBE;
          else if (use_ack)        st <= ST_ACKSEEN;
          else                     st <= ST_RELEASE;
        end
        ST_ACKSEEN: if (rise) st <= ST_RELEASE;
        ST_RELEASE: if (fall) begin
          st <= ST_TAIL;
          wr <= 1'b0;
        end
        ST_TAIL: if (rise) begin
          if (hold) begin
            st <= ST_HOLD;
          end else begin
            st   <= ST_IDLE;
            cs   <= 1'b0;
            oe   <= 1'b0;
            busy <= 1'b0;
          end
        end
        ST_HOLD: if (rise) begin
          st   <= ST_IDLE;
          cs   <= 1'b0;
          oe   <= 1'b0;
          busy <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebw_write_ctrl.sv
module ebw_write_ctrl
  import ebw_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [1:0]         cfg_mode,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               cfg_hold,
  input  logic               req,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  output logic               busy,
  output logic               bus_clk,
  output logic               bus_cs,
  output logic               bus_wr,
  output logic               bus_oe,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_data,
  input  logic               bus_ack
);
  logic              rise_tick, fall_tick;
  logic              accept;
  logic              wait_load, wait_dec, wait_done;
  logic [WAIT_W-1:0] wait_q;
  logic              use_ack_q, hold_q;
  ebw_mode_e         mode_in;

  assign mode_in = ebw_mode_e'(cfg_mode);
  assign accept  = req && !busy;

  // Request capture: configuration and payload are frozen per access
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= '0;
      use_ack_q <= 1'b0;
      hold_q    <= 1'b0;
      bus_addr  <= '0;
      bus_data  <= '0;
    end else if (accept) begin
      wait_q    <= (mode_in == MODE_ACK) ? '0 : cfg_wait;
      use_ack_q <= (mode_in != MODE_COUNT);
      hold_q    <= cfg_hold;
      bus_addr  <= req_addr;
      bus_data  <= req_data;
    end
  end

  ebw_clkgen #(.RATIO_W(RATIO_W)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .ratio     (cfg_ratio),
    .pclk      (bus_clk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  ebw_waitcnt #(.WAIT_W(WAIT_W)) u_waitcnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wait_load),
    .load_val (wait_q),
    .dec      (wait_dec),
    .expired  (wait_done)
  );

  ebw_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise_tick),
    .fall      (fall_tick),
    .start     (accept),
    .use_ack   (use_ack_q),
    .ack       (bus_ack),
    .wait_done (wait_done),
    .hold      (hold_q),
    .busy      (busy),
    .cs        (bus_cs),
    .wr        (bus_wr),
    .oe        (bus_oe),
    .wait_load (wait_load),
    .wait_dec  (wait_dec)
  );
endmodule

// File: rtl/ebw_write_ctrl_chk.sv
module ebw_write_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              bus_clk,
  input logic              bus_cs,
  input logic              bus_wr,
  input logic              bus_oe,
  input logic [ADDR_W-1:0] bus_addr
);
  AST_WR_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> bus_cs); // R3
  AST_CS_BEFORE_WR: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr) |-> $past(bus_cs)); // R3
  AST_CS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cs) |-> $rose(bus_clk)); // R3
  AST_WR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_wr) || $fell(bus_wr)) |-> $fell(bus_clk)); // R3
  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> bus_cs); // R4
  AST_OE_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> ($past(bus_wr) && $rose(bus_clk))); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && $past(bus_cs)) |-> $stable(bus_addr)); // R4
  AST_CS_DROP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs) |-> ($rose(bus_clk) && !bus_wr)); // R9
  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (rst)
    bus_cs |-> busy); // R2
endmodule

bind ebw_write_ctrl ebw_write_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .bus_clk  (bus_clk),
  .bus_cs   (bus_cs),
  .bus_wr   (bus_wr),
  .bus_oe   (bus_oe),
  .bus_addr (bus_addr)
);

// File: tb/ebw_write_ctrl_test.sv
`timescale 1ns/1ps
module ebw_write_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;
  localparam int RW = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  wt;
    logic        hold;
    logic [3:0]  ratio;
    logic [3:0]  k;      // rising edges with ack low
    logic [3:0]  s;      // expected strobe length, port cycles
    logic [15:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0, 1'b0, 4'd0, 4'd0, 4'd1, 16'h1000, 16'hA5A5}, // R5 zero wait
    '{2'd0, 4'd3, 1'b1, 4'd1, 4'd0, 4'd4, 16'h1234, 16'h0F0F}, // R5 R9
    '{2'd1, 4'd5, 1'b0, 4'd0, 4'd0, 4'd2, 16'h2222, 16'h5555}, // R6 R7
    '{2'd1, 4'd0, 1'b1, 4'd2, 4'd3, 4'd5, 16'h3333, 16'hAAAA}, // R6 R7 R9
    '{2'd2, 4'd2, 1'b0, 4'd1, 4'd0, 4'd4, 16'h4444, 16'h1111}, // R8
    '{2'd2, 4'd2, 1'b0, 4'd0, 4'd5, 4'd7, 16'h5A5A, 16'hC3C3}, // R8 ack late
    '{2'd2, 4'd4, 1'b1, 4'd0, 4'd2, 4'd6, 16'h6666, 16'h7E7E}, // R8 ack early
    '{2'd3, 4'd1, 1'b0, 4'd1, 4'd1, 4'd3, 16'h7777, 16'h8181}, // R8 alt code
    '{2'd0, 4'd1, 1'b0, 4'd0, 4'd4, 4'd2, 16'h8888, 16'h9999}  // R5 ack ignored
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] cfg_ratio = '0;
  logic [1:0]    cfg_mode = '0;
  logic [WW-1:0] cfg_wait = '0;
  logic          cfg_hold = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, bus_clk, bus_cs, bus_wr, bus_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          bus_ack = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ebw_write_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW), .RATIO_W(RW)) uut (
    .clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .cfg_mode(cfg_mode),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .req(req), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .bus_clk(bus_clk), .bus_cs(bus_cs),
    .bus_wr(bus_wr), .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ack(bus_ack)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One access; intrude=1 issues a second request mid-access with new settings
  task automatic run_access(input vec_t v, input bit intrude, input string tag);
    int  n_wr = 0, n_cs = 0, n_oe = 0, bad = 0, guard = 0;
    bit  prev, seen_busy = 0, poked = 0;
    @(negedge clk);
    cfg_ratio = v.ratio; cfg_mode = v.mode; cfg_wait = v.wt; cfg_hold = v.hold;
    req_addr = v.addr; req_data = v.data;
    bus_ack = (v.k == 0);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    prev = bus_clk;
    while (guard < 4000) begin
      guard++;
      if (busy) seen_busy = 1;
      if (seen_busy && !busy) break;
      if (bus_clk && !prev) begin
        if (bus_wr) n_wr++;
        if (bus_cs) n_cs++;
        if (bus_oe) n_oe++;
        if (bus_wr && !bus_ack && n_wr >= v.k) bus_ack = 1'b1;
      end
      if (bus_cs && bus_addr !== v.addr) bad++;
      if (bus_oe && bus_data !== v.data) bad++;
      prev = bus_clk;
      if (intrude && n_cs == 1 && !poked) begin
        poked = 1;
        req = 1'b1; req_addr = ~v.addr; req_data = ~v.data; cfg_wait = '0;
        cfg_hold = ~v.hold;
        @(negedge clk);
        req = 1'b0;
        if (bus_cs && bus_addr !== v.addr) bad++;
        prev = prev; // rising edges are tracked on the next iteration
      end else begin
        @(negedge clk);
      end
    end
    chk({tag, " R3/R5-R8 strobe cycles"}, n_wr, int'(v.s));
    chk({tag, " R7/R9 select cycles"}, n_cs, int'(v.s) + 1 + int'(v.hold));
    chk({tag, " R4/R9 driver cycles"}, n_oe, int'(v.s) + int'(v.hold));
    chk({tag, " R4 addr/data stable"}, bad, 0);
    chk({tag, " R2 idle after access"}, {bus_cs, bus_wr, bus_oe}, 0);
    bus_ack = 1'b1;
  endtask

  initial begin
    int t;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {busy, bus_clk, bus_cs, bus_wr, bus_oe}, 0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_access(VECS[i], 1'b0, $sformatf("vec%0d", i));
    end

    // R1 port clock half period
    for (int r = 0; r < 3; r++) begin
      bit p;
      @(negedge clk);
      cfg_ratio = RW'(r);
      repeat (12) @(negedge clk);
      p = bus_clk;
      while (bus_clk == p) @(negedge clk);
      p = bus_clk;
      t = 0;
      while (bus_clk == p && t < 100) begin
        @(negedge clk);
        t++;
      end
      chk($sformatf("R1 half period ratio=%0d", r), t, r + 1);
    end

    // R2 / R10: request during an access is ignored, config frozen
    run_access('{2'd0, 4'd3, 1'b0, 4'd1, 4'd0, 4'd4, 16'hBEEF, 16'h1357}, 1'b1, "intrude");
    t = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (bus_cs || busy) t++;
    end
    chk("R2 ignored request starts nothing", t, 0);

    // R5 back-to-back zero-wait accesses at fastest ratio
    run_access('{2'd0, 4'd0, 1'b1, 4'd0, 4'd0, 4'd1, 16'hFFFF, 16'h0000}, 1'b0, "b2b0");
    run_access('{2'd0, 4'd0, 1'b0, 4'd0, 4'd0, 4'd1, 16'h0001, 16'hFFFE}, 1'b0, "b2b1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule